// File: doc/BRIEF.md
# GPIO Power Mode Controller

This block decides the power state of a 32-pin general-purpose I/O peripheral and turns that state into clock-enable outputs. It drives separate enables for the bus-interface logic, the input-data sampler and four 8-pin event-detection groups. It also drives a signal that permits interrupts. The enables are synchronous clock-enable outputs. The clock-gating cells, the bus protocol and the input debouncer sit outside the block.

The block has four power states. Active is the normal state. A host can ask for a low-power state on a sideband request line, and a configuration input chooses which of two low-power states that request enters. In the light state (Idle) the event-detection enables keep running. In the deep state (Inactive) they are off. A software disable bit overrides everything else and moves the block to Disabled. In Disabled every internal enable is removed except the bus-interface enable. The event detector also has a one-in-N slowdown, with N = 1, 2, 4 or 8, so that its logic is clocked only once every N cycles.

Top module: `gpio_pwr_ctrl`

## Requirements
- R1: After reset the block is in Active with idle_ack_o low and irq_allow_o high. The auto-idle register is cleared, so bus_clk_en_o is high even while auto_idle_i is high and bus_act_i is low.
- R2: mode_o reports the state with Active=0, Idle=1, Inactive=2 and Disabled=3. In Active, with idle_req_i high and sw_disable_i low at a rising edge, the block moves to Idle (idle_deep_i=0) or Inactive (idle_deep_i=1) at that edge. idle_ack_o is high from that edge on.
- R3: In Idle or Inactive, with idle_req_i low at a rising edge, the block returns to Active at that edge and idle_ack_o falls.
- R4: With sw_disable_i high at a rising edge, the block enters Disabled at that edge from any state. In Disabled, smp_clk_en_o and every bit of det_clk_en_o are low and idle_ack_o is low.
- R5: irq_allow_o is high only in Active.
- R6: bus_clk_en_o equals the inverse of the registered auto-idle bit, ORed with bus_act_i. The registered bit takes auto_idle_i at every rising edge. The power state does not affect this enable, and it stays available in Disabled.
- R7: smp_clk_en_o is high only in Active while din_rd_i is high.
- R8: det_clk_en_o[g] is high only in Active or Idle, only when at least one bit of det_cfg_i[8g+7:8g] is set, and only on a detector tick.
- R9: The detector tick occurs when the number of rising edges since reset, taken modulo N, is zero. N = 2^div_sel_i, so codes 0, 1, 2 and 3 give N = 1, 2, 4 and 8.
- R10: When sw_disable_i falls, the block returns to Active at the next rising edge. The event-detection enables come back in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Host sideband low-power request |
| idle_deep_i | input | 1 | Selects Inactive (1) or Idle (0) for a request |
| sw_disable_i | input | 1 | Software disable bit |
| auto_idle_i | input | 1 | Auto-idle configuration bit for the bus interface |
| bus_act_i | input | 1 | A bus access is in progress |
| din_rd_i | input | 1 | The data-in register is being read |
| det_cfg_i | input | 32 | Per-pin event-detection configured flags |
| div_sel_i | input | 2 | Detector slowdown code; N = 2^code |
| mode_o | output | 2 | Current power state |
| idle_ack_o | output | 1 | Low-power request acknowledged |
| irq_allow_o | output | 1 | Interrupt generation permitted |
| bus_clk_en_o | output | 1 | Bus-interface clock enable |
| smp_clk_en_o | output | 1 | Input-sampler clock enable |
| det_clk_en_o | output | 4 | Event-detector clock enable per 8-pin group |

## Verification
The bench pulls the disable bit while a low-power request is held. A design that lets the request win would report Idle or keep the acknowledge high. It releases the disable bit and checks the detector enables in the very next cycle; a design with an extra recovery cycle would show them low there. It sweeps all four slowdown codes against the edge count since reset; an off-by-one mask would tick at the wrong phase or on every other period. It also leaves two 8-pin groups unconfigured, which catches a design that enables every group or slices the wrong bits. Finally it raises auto_idle_i during reset, which exposes an auto-idle bit that is not cleared or that takes effect without the register delay.

// File: rtl/gpio_pwr_pkg.sv
package gpio_pwr_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE   = 2'd0,
    PM_IDLE     = 2'd1,
    PM_INACTIVE = 2'd2,
    PM_DISABLED = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/gpio_pwr_fsm.sv
module gpio_pwr_fsm
  import gpio_pwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      idle_req_i,
  input  logic      idle_deep_i,
  input  logic      sw_disable_i,
  output pwr_mode_e mode_o
);
  pwr_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (sw_disable_i) begin
      mode_d = PM_DISABLED;  // software disable outranks host request
    end else begin
      unique case (mode_q)
        PM_ACTIVE:   if (idle_req_i) mode_d = idle_deep_i ? PM_INACTIVE : PM_IDLE;
        PM_IDLE,
        PM_INACTIVE: if (!idle_req_i) mode_d = PM_ACTIVE;
        PM_DISABLED: mode_d = PM_ACTIVE;
        default:     mode_d = PM_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PM_ACTIVE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/gpio_det_gate.sv
module gpio_det_gate #(
  parameter int NUM_PINS  = 32,
  parameter int GRP_W     = 8,
  parameter int DIV_SEL_W = 2,
  localparam int NUM_GRP  = NUM_PINS / GRP_W,
  localparam int CNT_W    = (1 << DIV_SEL_W) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [NUM_PINS-1:0]  det_cfg_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic [NUM_GRP-1:0]   det_en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // low div_sel_i bits of the phase counter must be zero for a tick
  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (32'(div_sel_i) > i);
  end

  assign tick = ((cnt_q & mask) == '0);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign det_en_o[g] = run_i & (|det_cfg_i[g*GRP_W +: GRP_W]) & tick;
  end
endmodule

// File: rtl/gpio_pwr_ctrl.sv
module gpio_pwr_ctrl
  import gpio_pwr_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int GRP_W     = 8,
  parameter int DIV_SEL_W = 2,
  localparam int NUM_GRP  = NUM_PINS / GRP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 idle_req_i,
  input  logic                 idle_deep_i,
  input  logic                 sw_disable_i,
  input  logic                 auto_idle_i,
  input  logic                 bus_act_i,
  input  logic                 din_rd_i,
  input  logic [NUM_PINS-1:0]  det_cfg_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic [1:0]           mode_o,
  output logic                 idle_ack_o,
  output logic                 irq_allow_o,
  output logic                 bus_clk_en_o,
  output logic                 smp_clk_en_o,
  output logic [NUM_GRP-1:0]   det_clk_en_o
);
  pwr_mode_e mode;
  logic      auto_idle_q;
  logic      det_run;

  gpio_pwr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_req_i   (idle_req_i),
    .idle_deep_i  (idle_deep_i),
    .sw_disable_i (sw_disable_i),
    .mode_o       (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) auto_idle_q <= 1'b0;
    else         auto_idle_q <= auto_idle_i;
  end

  // light idle keeps detection clocked, deep idle and disable stop it
  assign det_run = (mode == PM_ACTIVE) || (mode == PM_IDLE);

  gpio_det_gate #(
    .NUM_PINS  (NUM_PINS),
    .GRP_W     (GRP_W),
    .DIV_SEL_W (DIV_SEL_W)
  ) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (det_run),
    .det_cfg_i (det_cfg_i),
    .div_sel_i (div_sel_i),
    .det_en_o  (det_clk_en_o)
  );

  assign mode_o       = mode;
  assign idle_ack_o   = (mode == PM_IDLE) || (mode == PM_INACTIVE);
  assign irq_allow_o  = (mode == PM_ACTIVE);
  assign bus_clk_en_o = !auto_idle_q || bus_act_i;
  assign smp_clk_en_o = (mode == PM_ACTIVE) && din_rd_i;
endmodule

// File: rtl/gpio_pwr_ctrl_chk.sv
module gpio_pwr_ctrl_chk #(
  parameter int NUM_GRP = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               idle_req_i,
  input logic               sw_disable_i,
  input logic               bus_act_i,
  input logic               din_rd_i,
  input logic [1:0]         mode_o,
  input logic               idle_ack_o,
  input logic               irq_allow_o,
  input logic               bus_clk_en_o,
  input logic               smp_clk_en_o,
  input logic [NUM_GRP-1:0] det_clk_en_o
);
  a_r2_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && idle_req_i && !sw_disable_i) |=> (idle_ack_o && (mode_o == 2'd1 || mode_o == 2'd2)));

  a_r3_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && !idle_req_i && !sw_disable_i) |=> (!idle_ack_o && mode_o == 2'd0));

  a_r4_dis_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_disable_i |=> (mode_o == 2'd3 && !idle_ack_o));

  a_r4_dis_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |-> (det_clk_en_o == '0 && !smp_clk_en_o));

  a_r5_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |-> !irq_allow_o);

  a_r6_bus_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |-> bus_clk_en_o);

  a_r7_smp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !din_rd_i |-> !smp_clk_en_o);

  a_r10_dis_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !sw_disable_i) |=> (mode_o == 2'd0));
endmodule

bind gpio_pwr_ctrl gpio_pwr_ctrl_chk #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idle_req_i   (idle_req_i),
  .sw_disable_i (sw_disable_i),
  .bus_act_i    (bus_act_i),
  .din_rd_i     (din_rd_i),
  .mode_o       (mode_o),
  .idle_ack_o   (idle_ack_o),
  .irq_allow_o  (irq_allow_o),
  .bus_clk_en_o (bus_clk_en_o),
  .smp_clk_en_o (smp_clk_en_o),
  .det_clk_en_o (det_clk_en_o)
);

// File: tb/gpio_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pwr_ctrl_tb;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        idle_req = 0, idle_deep = 0, sw_dis = 0, auto_idle = 0, bus_act = 0, din_rd = 0;
  logic [31:0] det_cfg = '0;
  logic [1:0]  div_sel = '0;
  logic [1:0]  mode;
  logic        ack, irq, bus_en, smp_en;
  logic [3:0]  det_en;

  logic [31:0] cfg_nx = 32'h0100_00FF;  // groups 0 and 3 configured
  logic [1:0]  div_nx = 2'd0;

  int          n_chk = 0, n_fail = 0;
  logic [1:0]  mode_m = 2'd0;
  logic        auto_m = 1'b0;
  int unsigned edges_m = 0;
  logic [9:0]  exp_q[$];
  string       tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  gpio_pwr_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .idle_req_i   (idle_req),
    .idle_deep_i  (idle_deep),
    .sw_disable_i (sw_dis),
    .auto_idle_i  (auto_idle),
    .bus_act_i    (bus_act),
    .din_rd_i     (din_rd),
    .det_cfg_i    (det_cfg),
    .div_sel_i    (div_sel),
    .mode_o       (mode),
    .idle_ack_o   (ack),
    .irq_allow_o  (irq),
    .bus_clk_en_o (bus_en),
    .smp_clk_en_o (smp_en),
    .det_clk_en_o (det_en)
  );

  function automatic logic [9:0] expect_vec(logic ba, logic dr);
    logic [3:0] d;
    logic run = (mode_m == 2'd0) || (mode_m == 2'd1);
    logic tk = ((edges_m % (32'd1 << div_sel)) == 0);
    for (int g = 0; g < 4; g++) d[g] = run && (|det_cfg[g*8 +: 8]) && tk;
    return {mode_m, (mode_m == 2'd1 || mode_m == 2'd2), (mode_m == 2'd0),
            (!auto_m || ba), (mode_m == 2'd0 && dr), d};
  endfunction

  function automatic void check(logic [9:0] got, logic [9:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got mode=%0d ack=%b irq=%b bus=%b smp=%b det=%b, expected mode=%0d ack=%b irq=%b bus=%b smp=%b det=%b",
               tag, got[9:8], got[7], got[6], got[5], got[4], got[3:0],
               exp[9:8], exp[7], exp[6], exp[5], exp[4], exp[3:0]);
    end
  endfunction

  task automatic step(input logic rq, input logic dp, input logic ds, input logic ai,
                      input logic ba, input logic dr, input string tag);
    @(negedge clk);
    idle_req = rq; idle_deep = dp; sw_dis = ds; auto_idle = ai; bus_act = ba; din_rd = dr;
    det_cfg = cfg_nx; div_sel = div_nx;
    @(posedge clk);
    edges_m++;
    auto_m = ai;
    if (ds)                                 mode_m = 2'd3;
    else if (mode_m == 2'd3)                mode_m = 2'd0;
    else if (mode_m == 2'd0 && rq)          mode_m = dp ? 2'd2 : 2'd1;
    else if (mode_m != 2'd0 && !rq)         mode_m = 2'd0;
    exp_q.push_back(expect_vec(ba, dr));
    tag_q.push_back(tag);
  endtask

  // monitor: compares queued expectations away from the edge
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) check({mode, ack, irq, bus_en, smp_en, det_en}, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    auto_idle = 1'b1; det_cfg = cfg_nx;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1 check({mode, ack, irq, bus_en, smp_en, det_en}, expect_vec(1'b0, 1'b0), "R1 reset state");

    // R6: auto-idle takes effect after its register
    step(0,0,0,1,0,0, "R6 auto-idle no access");
    step(0,0,0,1,1,0, "R6 auto-idle with access");
    step(0,0,0,0,0,0, "R6 auto-idle cleared");
    step(0,0,0,1,0,1, "R7 sampler on read");
    step(0,0,0,1,0,0, "R7 sampler off");

    // R9/R8: every slowdown code across a full period
    for (int c = 0; c < 4; c++) begin
      div_nx = 2'(c);
      for (int k = 0; k < 9; k++) step(0,0,0,0,0,0, "R9 tick phase");
    end
    div_nx = 2'd1;

    // R2/R3: light idle keeps detection, blocks sampler and irq
    step(1,0,0,1,0,1, "R2 enter idle");
    step(1,0,0,1,0,1, "R7 R5 held idle");
    step(1,0,0,1,0,0, "R8 idle detect");
    step(0,0,0,1,0,0, "R3 leave idle");
    step(0,0,0,1,0,0, "R3 active again");

    // deep idle gates detection
    step(1,1,0,0,0,0, "R2 enter inactive");
    step(1,1,0,0,0,0, "R8 inactive no detect");
    step(1,0,0,0,0,0, "R2 deep sel change held");
    step(0,0,0,0,0,0, "R3 leave inactive");

    // R4: disable overrides a held request
    step(1,0,0,1,0,0, "R2 idle before disable");
    step(1,0,1,1,0,1, "R4 disable over request");
    step(1,0,1,1,1,1, "R6 bus in disabled");
    step(0,0,1,0,0,1, "R4 held disabled");
    step(0,0,1,0,0,1, "R4 held disabled 2");
    step(0,0,0,0,0,1, "R10 disable released");
    step(0,0,0,0,0,0, "R10 detect back");
    div_nx = 2'd0;
    step(0,0,1,0,0,0, "R4 disable from active");
    step(0,0,0,0,0,0, "R10 immediate detect");

    // R8: unconfigured groups stay off
    cfg_nx = 32'h0000_FF00;
    step(0,0,0,0,0,0, "R8 only group 1");
    cfg_nx = 32'h0000_0000;
    step(0,0,0,0,0,0, "R8 no groups");
    cfg_nx = 32'h0080_0000;
    step(0,0,0,0,0,0, "R8 only group 2");
    step(0,0,0,0,0,0, "R5 active irq");

    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule